// File: doc/BRIEF.md
# Gray-Code Self-Test Pattern Generator

This block feeds the inputs of a combinational logic cone during built-in self-test. It steps an n-bit word through every one of its 2^n values in reflected Gray-code order. Each new word differs from the one before it in a single bit. The exhaustive sweep gives full input coverage. The single-bit change keeps switching activity in the cone under test low.

Every bit of the pattern register has its own enable. On any step, only the one bit that changes receives an enable. The others are not clocked at all. The enable vector is brought out so that a clock-gating cell per bit can use it, or a checker can watch it.

A one-cycle `start_i` pulse loads the all-zero pattern and arms the sweep. While `run_i` is high, the block advances one pattern per clock. When the final pattern appears, the block raises `done_o` and holds that pattern until a new start or a reset.

Top module: `gray_bist_tpg`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) leaves `pattern_o` all zero, with `valid_o`, `done_o` and every bit of `bit_en_o` low.
- R2: A `start_i` pulse at a clock edge makes `pattern_o` all zero, `valid_o` high and `done_o` low after that edge, and arms the sweep. `start_i` takes priority over stepping.
- R3: After the k-th step since the last start, `pattern_o` equals k XOR (k shifted right by one), with bit 0 as the least significant bit.
- R4: Two consecutive patterns produced by a step differ in exactly one bit position.
- R5: During a step, `bit_en_o` has exactly one bit set, and it equals the XOR of the pattern before and after the edge. Outside a step, `bit_en_o` is all zero.
- R6: While the sweep is armed and `run_i` is low, `pattern_o` does not change, `valid_o` is low after the edge, and `bit_en_o` is zero.
- R7: `valid_o` is high for exactly the one cycle after each start or step, and low otherwise.
- R8: Between a start and `done_o`, all 2^WIDTH patterns are presented with `valid_o` high, and each appears exactly once.
- R9: `done_o` rises together with the last pattern, which is a one in bit WIDTH-1 and zeros elsewhere. After that, `run_i` has no effect: the pattern stays, `valid_o` stays low and `bit_en_o` stays zero until a start or reset.
- R10: A start issued in mid-sweep or after `done_o` restarts the sweep from the all-zero pattern and clears `done_o`.
- R11: The bit that toggles on a step is bit 0 when the current pattern has even parity. Otherwise it is the bit just above the lowest set bit of the current pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Restart pulse: load zero pattern and arm the sweep |
| run_i | input | 1 | Advance one pattern per clock while high |
| pattern_o | output | WIDTH | Current test pattern |
| valid_o | output | 1 | High for one cycle when a new pattern is presented |
| done_o | output | 1 | Full sweep has been presented |
| bit_en_o | output | WIDTH | Per-bit enable for the coming edge, one-hot during a step |

## Verification
A wrong toggle choice or a corrupted pattern bit shows at the ports on the very next step. The new word then breaks the Gray formula for its step index, or it differs from its predecessor in other than one bit. It also disagrees with the enable vector presented just before the edge. A miscounted step counter does not show in the pattern at once. It shows at the end of the sweep, where `done_o` comes one step early or late, or where a pattern repeats or is missing from the set marked as seen. A stuck or leaking enable shows in the same cycle: `bit_en_o` is non-zero while `run_i` is low or after done, or it is not one-hot during a step.

// File: rtl/gray_bist_pkg.sv
package gray_bist_pkg;

    // Sequencer flags shared by the controller and its checker
    typedef struct packed {
        logic armed;   // sweep in progress
        logic fin;     // last pattern reached
        logic fresh;   // a new pattern was just loaded
    } seq_flags_t;

    localparam seq_flags_t SEQ_IDLE = '{armed: 1'b0, fin: 1'b0, fresh: 1'b0};

endpackage

// File: rtl/gray_bit_cell.sv
// One pattern bit with its own enable: it toggles only when enabled.
module gray_bit_cell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic en_i,
    output logic q_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q;
        if (clr_i)     bit_d = 1'b0;
        else if (en_i) bit_d = ~bit_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) bit_q <= 1'b0;
        else       bit_q <= bit_d;
    end

    assign q_o = bit_q;
endmodule

// File: rtl/gray_step_sel.sv
// Chooses the single bit that the next Gray step flips, from the pattern alone.
module gray_step_sel #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pattern_i,
    output logic [WIDTH-1:0] sel_o
);
    logic             odd_par;
    logic [WIDTH-1:0] low_set;

    always_comb begin
        odd_par = ^pattern_i;
        low_set = pattern_i & (~pattern_i + {{(WIDTH-1){1'b0}}, 1'b1});
        if (!odd_par) sel_o = {{(WIDTH-1){1'b0}}, 1'b1};
        else          sel_o = low_set << 1;
    end
endmodule

// File: rtl/gray_seq_ctrl.sv
// Step counter and sweep flags.
module gray_seq_ctrl
    import gray_bist_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic run_i,
    output logic step_o,
    output logic valid_o,
    output logic done_o
);
    localparam logic [WIDTH-1:0] PENULT = {{(WIDTH-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [WIDTH-1:0] count;
        seq_flags_t       flags;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  step;

    always_comb begin
        step   = ctrl_q.flags.armed && run_i && !start_i;
        ctrl_d = ctrl_q;
        ctrl_d.flags.fresh = 1'b0;
        if (start_i) begin
            ctrl_d.count = '0;
            ctrl_d.flags = '{armed: 1'b1, fin: 1'b0, fresh: 1'b1};
        end else if (step) begin
            ctrl_d.count       = ctrl_q.count + 1'b1;
            ctrl_d.flags.fresh = 1'b1;
            if (ctrl_q.count == PENULT) begin
                ctrl_d.flags.armed = 1'b0;
                ctrl_d.flags.fin   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctrl_q <= '{count: '0, flags: SEQ_IDLE};
        else       ctrl_q <= ctrl_d;
    end

    assign step_o  = step;
    assign valid_o = ctrl_q.flags.fresh;
    assign done_o  = ctrl_q.flags.fin;
endmodule

// File: rtl/gray_bist_tpg.sv
// Exhaustive Gray-code pattern generator with per-bit enables.
module gray_bist_tpg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             run_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic             valid_o,
    output logic             done_o,
    output logic [WIDTH-1:0] bit_en_o
);
    logic             step;
    logic [WIDTH-1:0] sel;
    logic [WIDTH-1:0] pat;
    logic [WIDTH-1:0] en;

    gray_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .run_i   (run_i),
        .step_o  (step),
        .valid_o (valid_o),
        .done_o  (done_o)
    );

    gray_step_sel #(.WIDTH(WIDTH)) u_sel (
        .pattern_i (pat),
        .sel_o     (sel)
    );

    assign en = step ? sel : '0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        gray_bit_cell u_cell (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .clr_i (start_i),
            .en_i  (en[i]),
            .q_o   (pat[i])
        );
    end

    assign pattern_o = pat;
    assign bit_en_o  = en;
endmodule

// File: rtl/gray_bist_tpg_chk.sv
module gray_bist_tpg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             run_i,
    input logic [WIDTH-1:0] pattern_o,
    input logic             valid_o,
    input logic             done_o,
    input logic [WIDTH-1:0] bit_en_o
);
    p_reset_state_r1: assert property (@(posedge clk_i)
        rst_i |=> (pattern_o == '0) && !valid_o && !done_o);

    p_start_load_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (pattern_o == '0) && valid_o && !done_o);

    p_single_flip_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_en_o != '0) |=> ($countones(pattern_o ^ $past(pattern_o)) == 1));

    p_en_onehot_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(bit_en_o));

    p_en_matches_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_en_o != '0) |=> (pattern_o == ($past(pattern_o) ^ $past(bit_en_o))));

    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_i && !start_i) |=> $stable(pattern_o) && !valid_o);

    p_valid_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_en_o == '0 && !start_i) |=> !valid_o);

    p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (bit_en_o == '0));

    p_parity_bit0_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        ((bit_en_o != '0) && !(^pattern_o)) |-> bit_en_o[0]);
endmodule

bind gray_bist_tpg gray_bist_tpg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .run_i     (run_i),
    .pattern_o (pattern_o),
    .valid_o   (valid_o),
    .done_o    (done_o),
    .bit_en_o  (bit_en_o)
);

// File: tb/gray_bist_tpg_test.sv
`timescale 1ns/1ps
module gray_bist_tpg_test;
    localparam int W     = 8;
    localparam int NPAT  = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         run = 1'b0;
    logic [W-1:0] pattern;
    logic         valid;
    logic         done;
    logic [W-1:0] bit_en;

    always #5 clk = ~clk;

    gray_bist_tpg #(.WIDTH(W)) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .start_i   (start),
        .run_i     (run),
        .pattern_o (pattern),
        .valid_o   (valid),
        .done_o    (done),
        .bit_en_o  (bit_en)
    );

    int total = 0;
    int bad   = 0;

    // behavioural model
    int m_step   = 0;
    bit m_armed  = 0;
    bit m_done   = 0;
    bit m_valid  = 0;
    bit seen [NPAT];
    int seen_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int gray_of(input int k);
        return k ^ (k >> 1);
    endfunction

    // flipped bit for step k -> k+1: position of lowest zero bit of k
    function automatic int flip_pos(input int k);
        for (int i = 0; i < 32; i++) if (((k >> i) & 1) == 0) return i;
        return 0;
    endfunction

    task automatic clear_seen();
        for (int i = 0; i < NPAT; i++) seen[i] = 0;
        seen_cnt = 0;
    endtask

    task automatic cyc(input bit st, input bit rn);
        bit         stepping;
        logic [W-1:0] prev_pat;
        logic [W-1:0] exp_en;
        @(negedge clk);
        start = st;
        run   = rn;
        #1;
        stepping = m_armed && rn && !st;
        exp_en   = stepping ? W'(1 << flip_pos(m_step)) : '0;
        chk(bit_en == exp_en, "R5 enable", int'(bit_en), int'(exp_en));
        if (stepping) begin
            // R11: toggle chosen from parity of current pattern
            if (!(^pattern))
                chk(bit_en == W'(1), "R11 even parity", int'(bit_en), 1);
        end
        if (m_armed && !rn && !st)
            chk(bit_en == '0, "R6 idle enable", int'(bit_en), 0);
        if (m_done && !st)
            chk(bit_en == '0, "R9 done enable", int'(bit_en), 0);
        prev_pat = pattern;
        @(posedge clk);
        if (st) begin
            m_step = 0; m_armed = 1; m_done = 0; m_valid = 1;
            clear_seen();
        end else if (stepping) begin
            m_step++;
            m_valid = 1;
            if (m_step == NPAT - 1) begin m_armed = 0; m_done = 1; end
        end else begin
            m_valid = 0;
        end
        #2;
        chk(pattern == W'(gray_of(m_step)), "R3 gray order", int'(pattern), gray_of(m_step));
        chk(valid == m_valid, "R7 valid", int'(valid), int'(m_valid));
        chk(done == m_done, "R9 done", int'(done), int'(m_done));
        if (st)
            chk(pattern == '0 && valid && !done, "R2 R10 start load", int'(pattern), 0);
        if (stepping) begin
            chk($countones(pattern ^ prev_pat) == 1, "R4 single flip",
                $countones(pattern ^ prev_pat), 1);
            chk((pattern ^ prev_pat) == exp_en, "R5 enable matches flip",
                int'(pattern ^ prev_pat), int'(exp_en));
        end else if (!st) begin
            chk(pattern == prev_pat, "R6 R9 pattern hold", int'(pattern), int'(prev_pat));
        end
        if (valid) begin
            chk(!seen[pattern], "R8 duplicate pattern", int'(pattern), 0);
            if (!seen[pattern]) seen_cnt++;
            seen[pattern] = 1;
        end
        if (m_done && stepping) begin
            chk(seen_cnt == NPAT, "R8 coverage", seen_cnt, NPAT);
            chk(pattern == W'(1 << (W - 1)), "R9 last pattern", int'(pattern), 1 << (W - 1));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_seen();
        repeat (3) @(posedge clk);
        #2;
        chk(pattern == '0 && !valid && !done && bit_en == '0, "R1 reset state",
            int'(pattern), 0);
        @(negedge clk);
        rst = 0;
        // idle before any start: nothing moves
        cyc(0, 1);
        // first sweep with periodic run gaps
        cyc(1, 0);
        for (int n = 0; n < 400 && !m_done; n++) cyc(0, (n % 7) != 3);
        chk(m_done == 1, "R8 sweep finished", int'(m_done), 1);
        // run stays high after done: no effect
        for (int n = 0; n < 5; n++) cyc(0, 1);
        // restart after done, then restart mid-sweep
        cyc(1, 1);
        for (int n = 0; n < 37; n++) cyc(0, 1);
        cyc(1, 1);
        for (int n = 0; n < NPAT + 4; n++) cyc(0, 1);
        chk(m_done == 1, "R10 second sweep finished", int'(m_done), 1);
        // reset in mid-sweep
        cyc(1, 1);
        for (int n = 0; n < 10; n++) cyc(0, 1);
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #2;
        chk(pattern == '0 && !valid && !done, "R1 reset mid-sweep", int'(pattern), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule